// File: doc/BRIEF.md
# Infrared Port Routing and Loopback Controller

This block sits beside an infrared serial engine and decides where the engine's serial lines go. A configuration register picks one of three physical ports (COM, IR, AUX) or parks all of them. The encoder's transmit line is sent to the chosen port, and the chosen port's receive line is sent to the decoder. Ports that are not chosen are held at a known level. When every port is parked, that level comes from a transmit-polarity bit.

The same register controls a self-test loopback. While loopback is on, the receiver feeds the data buffer and the buffer feeds the transmitter, so the engine runs full duplex against itself. In this block the encoder line is wired straight back to the decoder, and `lb_active` tells the buffer logic to cross its paths. Loopback can only be entered while the operating-mode field is zero. In consumer-IR mode it switches itself off when the receive byte counter runs out. The block also decides whether the single shared CRC unit generates on the transmit side or checks on the receive side.

Port selection can be written through two registers: the main configuration register and a short legacy alias. Whichever register was written last decides the selection, and both registers read back the same value.

Top module: `irx_port_ctl`

## Requirements
- R1: A synchronous active-high `rst` clears every register bit, so after reset `cfg_rdata`, `leg_rdata` and `mode_rdata` all read 0.
- R2: Select value 0 routes `enc_tx` to `port_tx[0]` (COM), 1 routes it to `port_tx[1]` (IR) and 2 routes it to `port_tx[2]` (AUX). Every other `port_tx` bit drives 0. Outside loopback, `dec_rx` takes `port_rx[select]`.
- R3: With select value 3, every `port_tx` bit equals the transmit-polarity bit (`mode_wdata[4]`). Outside loopback, `dec_rx` is 0.
- R4: A `cfg_wr` loads select from `cfg_wdata[7:6]`, and a `leg_wr` loads it from `leg_wdata[1:0]`. The later write wins. If both writes come in the same cycle, `cfg_wr` wins. `cfg_rdata[7:6]` and `leg_rdata` always show the same value.
- R5: A `cfg_wr` with `cfg_wdata[5]`=1 sets loopback only when the mode field (`mode_wdata[2:0]` as last written) is 0. If loopback is already set, it stays set. The same write still updates the other fields. A `cfg_wr` with bit 5 = 0 always clears loopback.
- R6: While loopback is set, `lb_active` is 1 and `dec_rx` follows `enc_tx`, whatever the select value is.
- R7: When the mode field equals the consumer-IR code (default 3) and `rx_cnt` is 0 in a cycle where it was 1 in the previous cycle, loopback clears at that clock edge. This auto-clear wins over a simultaneous write that tries to set loopback. It does not fire in any other mode.
- R8: While loopback is set, `cfg_wdata[4]` (stored) = 1 gives `crc_gen_en`=1 and `crc_chk_en`=0. If the stored bit is 0, the outputs are `crc_gen_en`=0 and `crc_chk_en`=1. The CRC-select bit has no effect in either case.
- R9: With loopback clear, CRC-select (`mode_wdata[3]`) = 0 drives both CRC enables to 0. With CRC-select = 1, direction bit `mode_wdata[5]` = 1 gives generation only, and 0 gives checking only.
- R10: `cfg_rdata[3:0]` and `mode_rdata[7:6]` always read 0. `cfg_rdata` = {select, loopback, loopback-CRC, 0000}, and `mode_rdata` = {00, direction, polarity, CRC-select, mode}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| leg_wr | input | 1 | Write strobe for the legacy select alias |
| leg_wdata | input | 2 | Legacy select write data |
| leg_rdata | output | 2 | Legacy select readback |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode, CRC-select, polarity and direction |
| mode_rdata | output | 8 | Mode register readback |
| enc_tx | input | 1 | Serial output of the encoder |
| dec_rx | output | 1 | Serial input to the decoder |
| port_tx | output | 3 | Transmit lines: bit0 COM, bit1 IR, bit2 AUX |
| port_rx | input | 3 | Receive lines, same order |
| rx_cnt | input | 8 | Received-byte down-counter |
| lb_active | output | 1 | Loopback on: buffer crosses receive to transmit |
| crc_gen_en | output | 1 | CRC unit generating on transmit |
| crc_chk_en | output | 1 | CRC unit checking on receive |

## Verification
The routing is driven with all four select values. Each one is paired with changing `enc_tx` and `port_rx` patterns, so a swapped port index, a stuck idle level or a wrong polarity source each produces a different mismatch. Interleaved and same-cycle writes through both select registers separate last-write-wins from a fixed priority. Loopback requests are made with zero and nonzero mode fields, and the counter is walked through 2→1→0 in consumer-IR mode and in another mode. This shows whether entry gating and auto-clear depend on the right conditions. A long mixed-random phase compares every output each cycle against a behavioural model.

// File: rtl/irx_pkg.sv
package irx_pkg;
  localparam int NPORT = 3;
  localparam int SELW  = 2;

  typedef enum logic [SELW-1:0] {
    PS_COM = 2'd0,
    PS_IR  = 2'd1,
    PS_AUX = 2'd2,
    PS_OFF = 2'd3
  } port_sel_e;

  typedef struct packed {
    logic gen;
    logic chk;
  } crc_en_t;

  // Level of transmit line idx for a given selection.
  function automatic logic tx_level(port_sel_e sel, int idx, logic enc, logic pol);
    if (sel == PS_OFF) return pol;
    return (int'(sel) == idx) ? enc : 1'b0;
  endfunction

  // Where the shared CRC unit goes.
  function automatic crc_en_t crc_steer(logic lb, logic lb_crc, logic crc_sel, logic dir_tx);
    crc_en_t r;
    if (lb) begin
      r.gen = lb_crc;
      r.chk = ~lb_crc;
    end else begin
      r.gen = crc_sel & dir_tx;
      r.chk = crc_sel & ~dir_tx;
    end
    return r;
  endfunction
endpackage

// File: rtl/irx_port_mux.sv
module irx_port_mux
  import irx_pkg::*;
(
  input  port_sel_e        sel,
  input  logic             enc_tx,
  input  logic             tx_pol,
  input  logic [NPORT-1:0] port_rx,
  output logic [NPORT-1:0] port_tx,
  output logic             rx_sel
);
  genvar i;
  generate
    for (i = 0; i < NPORT; i++) begin : g_tx
      assign port_tx[i] = tx_level(sel, i, enc_tx, tx_pol);
    end
  endgenerate

  always_comb begin
    rx_sel = 1'b0;
    for (int k = 0; k < NPORT; k++)
      if (int'(sel) == k) rx_sel = port_rx[k];
  end
endmodule

// File: rtl/irx_lb_ctl.sv
module irx_lb_ctl #(
  parameter int CW       = 8,
  parameter int MODEW    = 3,
  parameter int CIR_MODE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_lb,
  input  logic [MODEW-1:0] mode,
  input  logic [CW-1:0]    rx_cnt,
  output logic             lb_q,
  output logic             autoclr,
  output logic             entry_blocked
);
  logic [CW-1:0] cnt_prev_q;
  logic          mode_idle;
  logic          lb_d;

  assign mode_idle     = (mode == '0);
  assign autoclr       = (mode == MODEW'(CIR_MODE)) && (cnt_prev_q == CW'(1)) && (rx_cnt == '0);
  assign entry_blocked = wr_en && wr_lb && !lb_q && !mode_idle;

  always_comb begin
    lb_d = lb_q;
    if (wr_en) lb_d = wr_lb ? (lb_q | mode_idle) : 1'b0;
    if (autoclr) lb_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_q       <= 1'b0;
      cnt_prev_q <= '0;
    end else begin
      lb_q       <= lb_d;
      cnt_prev_q <= rx_cnt;
    end
  end
endmodule

// File: rtl/irx_port_ctl.sv
module irx_port_ctl
  import irx_pkg::*;
#(
  parameter int CW       = 8,
  parameter int CIR_MODE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             leg_wr,
  input  logic [SELW-1:0]  leg_wdata,
  output logic [SELW-1:0]  leg_rdata,
  input  logic             mode_wr,
  input  logic [7:0]       mode_wdata,
  output logic [7:0]       mode_rdata,
  input  logic             enc_tx,
  output logic             dec_rx,
  output logic [NPORT-1:0] port_tx,
  input  logic [NPORT-1:0] port_rx,
  input  logic [CW-1:0]    rx_cnt,
  output logic             lb_active,
  output logic             crc_gen_en,
  output logic             crc_chk_en
);
  localparam int MODEW = 3;

  port_sel_e        sel_q;
  logic             lbcrc_q;
  logic [MODEW-1:0] mode_q;
  logic             crcsel_q, txpol_q, dirtx_q;
  logic             lb_q, autoclr, entry_blocked;
  logic             rx_sel;
  crc_en_t          crc_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= PS_COM;
      lbcrc_q  <= 1'b0;
      mode_q   <= '0;
      crcsel_q <= 1'b0;
      txpol_q  <= 1'b0;
      dirtx_q  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        sel_q   <= port_sel_e'(cfg_wdata[7:6]);
        lbcrc_q <= cfg_wdata[4];
      end else if (leg_wr) begin
        sel_q   <= port_sel_e'(leg_wdata);
      end
      if (mode_wr) begin
        mode_q   <= mode_wdata[MODEW-1:0];
        crcsel_q <= mode_wdata[3];
        txpol_q  <= mode_wdata[4];
        dirtx_q  <= mode_wdata[5];
      end
    end
  end

  irx_lb_ctl #(.CW(CW), .MODEW(MODEW), .CIR_MODE(CIR_MODE)) u_lb (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_lb(cfg_wdata[5]),
    .mode(mode_q), .rx_cnt(rx_cnt), .lb_q(lb_q), .autoclr(autoclr),
    .entry_blocked(entry_blocked)
  );

  irx_port_mux u_mux (
    .sel(sel_q), .enc_tx(enc_tx), .tx_pol(txpol_q), .port_rx(port_rx),
    .port_tx(port_tx), .rx_sel(rx_sel)
  );

  irx_crc_route u_crc (
    .lb(lb_q), .lb_crc(lbcrc_q), .crc_sel(crcsel_q), .dir_tx(dirtx_q), .en(crc_en)
  );

  assign dec_rx     = lb_q ? enc_tx : rx_sel;
  assign lb_active  = lb_q;
  assign crc_gen_en = crc_en.gen;
  assign crc_chk_en = crc_en.chk;
  assign cfg_rdata  = {sel_q, lb_q, lbcrc_q, 4'b0000};
  assign leg_rdata  = sel_q;
  assign mode_rdata = {2'b00, dirtx_q, txpol_q, crcsel_q, mode_q};
endmodule

// File: rtl/irx_crc_route.sv
module irx_crc_route
  import irx_pkg::*;
(
  input  logic    lb,
  input  logic    lb_crc,
  input  logic    crc_sel,
  input  logic    dir_tx,
  output crc_en_t en
);
  assign en = crc_steer(lb, lb_crc, crc_sel, dir_tx);
endmodule

// File: rtl/irx_port_ctl_chk.sv
module irx_port_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic       leg_wr,
  input logic [1:0] leg_wdata,
  input logic [2:0] mode_q,
  input logic       lb_q,
  input logic       autoclr,
  input logic       entry_blocked,
  input logic       txpol_q,
  input logic [2:0] port_tx,
  input logic [7:0] cfg_rdata,
  input logic [1:0] leg_rdata,
  input logic       crc_gen_en,
  input logic       crc_chk_en
);
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (cfg_rdata == 8'h00));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[7:6] == 2'b11) |-> (port_tx == {3{txpol_q}}));

  assert_single_port_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[7:6] != 2'b11) |-> ($countones(port_tx) <= 1));

  assert_legacy_write_R4: assert property (@(posedge clk) disable iff (rst)
    (leg_wr && !cfg_wr) |=> (leg_rdata == $past(leg_wdata)));

  assert_alias_match_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[7:6] == leg_rdata);

  assert_entry_refused_R5: assert property (@(posedge clk) disable iff (rst)
    entry_blocked |=> !lb_q);

  assert_autoclear_R7: assert property (@(posedge clk) disable iff (rst)
    autoclr |=> !lb_q);

  assert_crc_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({crc_gen_en, crc_chk_en}));

  assert_lb_crc_side_R8: assert property (@(posedge clk) disable iff (rst)
    lb_q |-> (crc_gen_en == cfg_rdata[4]) && (crc_chk_en == !cfg_rdata[4]));
endmodule

bind irx_port_ctl irx_port_ctl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .leg_wr(leg_wr), .leg_wdata(leg_wdata), .mode_q(mode_q), .lb_q(lb_q),
  .autoclr(autoclr), .entry_blocked(entry_blocked), .txpol_q(txpol_q),
  .port_tx(port_tx), .cfg_rdata(cfg_rdata), .leg_rdata(leg_rdata),
  .crc_gen_en(crc_gen_en), .crc_chk_en(crc_chk_en)
);

// File: tb/irx_port_ctl_bench.sv
`timescale 1ns/1ps
module irx_port_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, leg_wr = 0, mode_wr = 0;
  logic [7:0] cfg_wdata = 0, mode_wdata = 0;
  logic [1:0] leg_wdata = 0;
  logic enc_tx = 0;
  logic [2:0] port_rx = 0;
  logic [7:0] rx_cnt = 0;
  logic [7:0] cfg_rdata, mode_rdata;
  logic [1:0] leg_rdata;
  logic dec_rx, lb_active, crc_gen_en, crc_chk_en;
  logic [2:0] port_tx;

  int n_chk = 0, n_err = 0;

  // reference model state
  int m_sel = 0, m_lb = 0, m_lbc = 0, m_mode = 0, m_crc = 0, m_pol = 0, m_dir = 0, m_prev = 0;

  always #10 clk = ~clk;

  irx_port_ctl u_irx_port_ctl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .leg_wr(leg_wr), .leg_wdata(leg_wdata), .leg_rdata(leg_rdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
    .enc_tx(enc_tx), .dec_rx(dec_rx), .port_tx(port_tx), .port_rx(port_rx),
    .rx_cnt(rx_cnt), .lb_active(lb_active), .crc_gen_en(crc_gen_en), .crc_chk_en(crc_chk_en)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_lb = 0; m_lbc = 0; m_mode = 0; m_crc = 0; m_pol = 0; m_dir = 0; m_prev = 0;
    end else begin
      int nlb;
      nlb = m_lb;
      if (cfg_wr) nlb = cfg_wdata[5] ? ((m_lb != 0 || m_mode == 0) ? 1 : 0) : 0;
      if (m_mode == 3 && m_prev == 1 && rx_cnt == 0) nlb = 0;
      m_lb = nlb;
      if (cfg_wr) begin m_sel = cfg_wdata[7:6]; m_lbc = cfg_wdata[4]; end
      else if (leg_wr) m_sel = leg_wdata;
      if (mode_wr) begin
        m_mode = mode_wdata[2:0]; m_crc = mode_wdata[3];
        m_pol = mode_wdata[4]; m_dir = mode_wdata[5];
      end
      m_prev = rx_cnt;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int etx, erx, egen, echk;
    etx = 0;
    for (int i = 0; i < 3; i++)
      if (m_sel == 3) etx |= (m_pol << i);
      else if (m_sel == i) etx |= (int'(enc_tx) << i);
    if (m_lb != 0) erx = enc_tx;
    else if (m_sel == 3) erx = 0;
    else erx = port_rx[m_sel];
    if (m_lb != 0) begin egen = m_lbc; echk = 1 - m_lbc; end
    else begin egen = m_crc & m_dir; echk = m_crc & (1 - m_dir); end
    chk(m_sel == 3 ? "R3 port_tx idle" : "R2 port_tx", port_tx, etx);
    chk(m_lb != 0 ? "R6 dec_rx loop" : "R2 dec_rx", dec_rx, erx);
    chk("R6 lb_active / R5 R7 loopback bit", lb_active, m_lb);
    chk(m_lb != 0 ? "R8 crc_gen" : "R9 crc_gen", crc_gen_en, egen);
    chk(m_lb != 0 ? "R8 crc_chk" : "R9 crc_chk", crc_chk_en, echk);
    chk("R10 R4 cfg_rdata", cfg_rdata, (m_sel << 6) | (m_lb << 5) | (m_lbc << 4));
    chk("R4 leg_rdata", leg_rdata, m_sel);
    chk("R10 mode_rdata", mode_rdata, (m_dir << 5) | (m_pol << 4) | (m_crc << 3) | m_mode);
  endtask

  // called at a negedge with inputs already set; checks, then moves to next negedge
  task automatic cyc();
    #2 compare();
    @(negedge clk);
    cfg_wr = 0; leg_wr = 0; mode_wr = 0;
  endtask

  task automatic wcfg(logic [7:0] d); cfg_wr = 1; cfg_wdata = d; cyc(); endtask
  task automatic wleg(logic [1:0] d); leg_wr = 1; leg_wdata = d; cyc(); endtask
  task automatic wmode(logic [7:0] d); mode_wr = 1; mode_wdata = d; cyc(); endtask

  task automatic wiggle(int n);
    for (int k = 0; k < n; k++) begin
      enc_tx = k[0]; port_rx = 3'(k * 5 + 1); cyc();
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cyc();                       // R1 during reset
    rst = 0;
    cyc();                       // R1 reset values
    // R2, R3: every selection with moving lines and both polarities
    for (int s = 0; s < 4; s++) begin
      wcfg(8'(s << 6)); wiggle(6);
      wmode(8'h10); wiggle(4); wmode(8'h00);
    end
    // R4: alias interplay
    wleg(2'd2); wiggle(2);
    wcfg(8'h40); wiggle(2);
    wleg(2'd3); wiggle(2);
    cfg_wr = 1; cfg_wdata = 8'h00; leg_wr = 1; leg_wdata = 2'd1; cyc();  // R4 same cycle
    // R5: loopback refused with nonzero mode, other fields still land
    wmode(8'h02); wcfg(8'hB0); wiggle(3);
    wmode(8'h00); wcfg(8'h20); wiggle(3);          // R5 entry allowed
    wmode(8'h05); wcfg(8'h30); wiggle(2);          // R5 stays set, R8 gen
    wcfg(8'h00); wiggle(2);                         // R5 clear always
    // R7: auto-clear in consumer-IR mode
    wmode(8'h00); wcfg(8'h20); wmode(8'h03);
    rx_cnt = 2; cyc(); rx_cnt = 1; cyc(); rx_cnt = 0; cyc(); wiggle(2);
    // R7: no auto-clear in another mode
    wmode(8'h00); wcfg(8'h20); wmode(8'h01);
    rx_cnt = 2; cyc(); rx_cnt = 1; cyc(); rx_cnt = 0; cyc(); wiggle(2);
    // R7: clear beats same-cycle set
    wmode(8'h03); rx_cnt = 1; cyc(); rx_cnt = 0; cfg_wr = 1; cfg_wdata = 8'h20; cyc();
    // R9: CRC in normal mode, both directions
    wcfg(8'h00); wmode(8'h08); wiggle(2); wmode(8'h28); wiggle(2); wmode(8'h20); wiggle(2);
    // mixed random
    for (int k = 0; k < 1500; k++) begin
      int r;
      r = $urandom;
      enc_tx = r[0]; port_rx = r[3:1];
      rx_cnt = 8'(r[5:4]);
      if (r[8:6] == 0) begin cfg_wr = 1; cfg_wdata = 8'($urandom); end
      if (r[11:9] == 0) begin leg_wr = 1; leg_wdata = 2'($urandom); end
      if (r[14:12] == 0) begin mode_wr = 1; mode_wdata = (r[15] ? 8'h00 : (r[16] ? 8'h03 : 8'($urandom))); end
      if (r[20:17] == 0) rst = 1; else rst = 0;
      cyc();
    end
    rst = 0; cyc();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule